// File: doc/BRIEF.md
# Oversampling UART Receiver with Noise Detection

This block recovers characters from an asynchronous serial line. A clock enable pulsing at sixteen times the baud rate paces it; each pulse takes one sample of the line, optionally inverted first. The receiver hunts for a falling edge, confirms the start bit with three early samples, then decides every bit of the frame by a two-of-three vote taken around the middle of the bit. Completed characters land in a single-entry data register.

Status outputs report a waiting character, an overrun, noise seen anywhere in the frame and a framing error. Each flag has its own clear strobe; reading the data clears the full flag. Falling edges inside a frame realign the sample counter, which tolerates a modest baud mismatch. After a framing error that is not a break, the edge history is forced to ones so that a start bit directly behind the bad stop bit is still caught. Delivery stays blocked while the framing error flag is set.

Top module: `uart_os_rx`

## Requirements
- R1: After reset, full_o, ovr_o, nf_o and fe_o are 0.
- R2: A frame of one 0 start bit, 8 data bits least significant first and a 1 stop bit puts the character on data_o and sets full_o once the stop bit is decided (sample 10 of the stop bit).
- R3: rd_i clears full_o; clr_ovr_i, clr_nf_i and clr_fe_i each clear only their own flag.
- R4: A character completed while full_o is 1 leaves data_o unchanged and sets ovr_o.
- R5: After a falling edge (a 0 sample following three 1 samples) the start is accepted only if at least two of samples 3, 5 and 7 are 0; otherwise the receiver returns to edge hunting and delivers nothing.
- R6: Each bit takes the majority of samples 8, 9 and 10; any sample among these, or among the start-check samples, that differs from its bit's value sets nf_o together with the transfer.
- R7: With nine_i = 1 the frame carries 9 data bits; the ninth appears on bit8_o. With nine_i = 0, bit8_o is 0.
- R8: With inv_i = 1 the line is inverted before sampling, so an inverted frame is received as its true value.
- R9: A falling edge seen after sample 10 of a bit starts the next bit at sample 1, so a transmitter whose bits last 15 samples is still received correctly.
- R10: A 0 stop bit sets fe_o; while fe_o is 1 no completed character enters the data register.
- R11: After a framing error whose data bits are not all 0, a start bit that begins right after sample 10 of the bad stop bit is received; after a break (all data and stop bits 0) a line that stays low starts no frame.
- R12: While rx_en_i is 0 no character is received and the data and flags change only through the clear strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Sample enable at 16x baud |
| rxd_i | input | 1 | Serial line |
| rx_en_i | input | 1 | Receiver enable |
| inv_i | input | 1 | Invert line before sampling |
| nine_i | input | 1 | 9 data bits when 1 |
| rd_i | input | 1 | Data read strobe, clears full_o |
| clr_ovr_i | input | 1 | Clears ovr_o |
| clr_nf_i | input | 1 | Clears nf_o |
| clr_fe_i | input | 1 | Clears fe_o |
| data_o | output | 8 | Received character, low 8 bits |
| bit8_o | output | 1 | Ninth data bit |
| full_o | output | 1 | Data register holds a character |
| ovr_o | output | 1 | Overrun flag |
| nf_o | output | 1 | Noise flag |
| fe_o | output | 1 | Framing error flag |

## Verification
The bench uses the package defaults of sixteen samples per bit and up to nine data bits, and holds tick_i high so that each clock is one sample slot. This lets the bench place a flipped sample on an exact slot (a start-check slot or a voting slot), shorten a stop bit to ten slots so the next start begins immediately, and send bits of fifteen slots to exercise realignment. Break and non-break framing errors are both followed by a low line, which exposes whether the edge history was preloaded.

// File: rtl/uart_os_rx_pkg.sv
package uart_os_rx_pkg;
  localparam int unsigned OVS      = 16;
  localparam int unsigned RT_W     = $clog2(OVS) + 1;
  localparam int unsigned MAX_DATA = 9;
  localparam int unsigned IDX_W    = $clog2(MAX_DATA + 2);
  localparam int unsigned HIST_W   = 3;

  localparam logic [RT_W-1:0] RT_FIRST = RT_W'(1);
  localparam logic [RT_W-1:0] RT_LAST  = RT_W'(OVS);
  localparam logic [RT_W-1:0] SLOT_S1  = RT_W'(3);
  localparam logic [RT_W-1:0] SLOT_S2  = RT_W'(5);
  localparam logic [RT_W-1:0] SLOT_S3  = RT_W'(7);
  localparam logic [RT_W-1:0] SLOT_V1  = RT_W'(OVS / 2);
  localparam logic [RT_W-1:0] SLOT_V2  = RT_W'(OVS / 2 + 1);
  localparam logic [RT_W-1:0] SLOT_V3  = RT_W'(OVS / 2 + 2);

  typedef enum logic {ST_HUNT, ST_FRAME} rx_state_e;
endpackage

// File: rtl/uart_os_rx_edge.sv
module uart_os_rx_edge
  import uart_os_rx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic adv_i,
  input  logic smp_i,
  input  logic preload_i,
  output logic edge_o
);
  logic [HIST_W-1:0] hist_q;

  assign edge_o = adv_i && (&hist_q) && !smp_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        hist_q <= '0;
    else if (!en_i)     hist_q <= '0;
    else if (adv_i) begin
      if (preload_i)    hist_q <= '1;
      else              hist_q <= {hist_q[HIST_W-2:0], smp_i};
    end
  end
endmodule

// File: rtl/uart_os_rx_core.sv
module uart_os_rx_core
  import uart_os_rx_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                adv_i,
  input  logic                smp_i,
  input  logic                edge_i,
  input  logic                nine_i,
  output logic                done_o,
  output logic [MAX_DATA-1:0] char_o,
  output logic                nf_o,
  output logic                stop_o,
  output logic                brk_o
);
  rx_state_e           state_q;
  logic [RT_W-1:0]     rt_q, rt_cur;
  logic [IDX_W-1:0]    idx_q, idx_cur, last_idx;
  logic                va_q, vb_q, nf_q, zero_q;
  logic [MAX_DATA-1:0] sh_q;
  logic                late, early, maj, dis, in_frame, vote_now;

  // realign only outside the voting window of the current bit
  assign late     = edge_i && (rt_q > SLOT_V3);
  assign early    = edge_i && (rt_q <= SLOT_S1);
  assign rt_cur   = (late || early || rt_q == RT_LAST) ? RT_FIRST : rt_q + 1'b1;
  assign idx_cur  = (late || (!early && rt_q == RT_LAST)) ? idx_q + 1'b1 : idx_q;
  assign last_idx = nine_i ? IDX_W'(MAX_DATA + 1) : IDX_W'(MAX_DATA);

  assign maj      = (va_q & vb_q) | (va_q & smp_i) | (vb_q & smp_i);
  assign dis      = !((va_q == vb_q) && (vb_q == smp_i));
  assign in_frame = (state_q == ST_FRAME) && adv_i && en_i;
  assign vote_now = in_frame && (rt_cur == SLOT_V3) && (idx_cur != '0);

  assign done_o = vote_now && (idx_cur == last_idx);
  assign char_o = sh_q;
  assign nf_o   = nf_q | dis;
  assign stop_o = maj;
  assign brk_o  = zero_q && !maj;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HUNT;
      rt_q    <= RT_FIRST;
      idx_q   <= '0;
      va_q    <= 1'b0;
      vb_q    <= 1'b0;
      nf_q    <= 1'b0;
      zero_q  <= 1'b0;
      sh_q    <= '0;
    end else if (!en_i) begin
      state_q <= ST_HUNT;
    end else if (adv_i) begin
      if (state_q == ST_HUNT) begin
        if (edge_i) begin
          state_q <= ST_FRAME;
          rt_q    <= RT_FIRST;
          idx_q   <= '0;
          nf_q    <= 1'b0;
          zero_q  <= 1'b1;
          sh_q    <= '0;
        end
      end else begin
        rt_q  <= rt_cur;
        idx_q <= idx_cur;
        if (idx_cur == '0) begin
          // start bit: confirm at S1..S3, then only watch for noise
          if (rt_cur == SLOT_S1) va_q <= smp_i;
          else if (rt_cur == SLOT_S2) vb_q <= smp_i;
          else if (rt_cur == SLOT_S3) begin
            if (maj) state_q <= ST_HUNT;
            else     nf_q    <= nf_q | va_q | vb_q | smp_i;
          end else if (rt_cur == SLOT_V1 || rt_cur == SLOT_V2 || rt_cur == SLOT_V3) begin
            nf_q <= nf_q | smp_i;
          end
        end else begin
          if (rt_cur == SLOT_V1) va_q <= smp_i;
          else if (rt_cur == SLOT_V2) vb_q <= smp_i;
          else if (rt_cur == SLOT_V3) begin
            nf_q <= nf_q | dis;
            if (idx_cur < last_idx) begin
              sh_q[idx_cur - 1'b1] <= maj;
              zero_q               <= zero_q & !maj;
            end else begin
              state_q <= ST_HUNT;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx
  import uart_os_rx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       rxd_i,
  input  logic       rx_en_i,
  input  logic       inv_i,
  input  logic       nine_i,
  input  logic       rd_i,
  input  logic       clr_ovr_i,
  input  logic       clr_nf_i,
  input  logic       clr_fe_i,
  output logic [7:0] data_o,
  output logic       bit8_o,
  output logic       full_o,
  output logic       ovr_o,
  output logic       nf_o,
  output logic       fe_o
);
  logic                smp, adv, edge_hit, preload;
  logic                done, frm_nf, stop_bit, brk;
  logic [MAX_DATA-1:0] chr, data_q;
  logic                full_q, ovr_q, nf_q, fe_q, deliver;

  assign smp     = rxd_i ^ inv_i;
  assign adv     = tick_i & rx_en_i;
  assign preload = done && !stop_bit && !brk;
  assign deliver = done && !fe_q;

  uart_os_rx_edge u_edge (
    .clk_i, .rst_ni, .en_i(rx_en_i), .adv_i(adv), .smp_i(smp),
    .preload_i(preload), .edge_o(edge_hit)
  );

  uart_os_rx_core u_core (
    .clk_i, .rst_ni, .en_i(rx_en_i), .adv_i(adv), .smp_i(smp),
    .edge_i(edge_hit), .nine_i, .done_o(done), .char_o(chr),
    .nf_o(frm_nf), .stop_o(stop_bit), .brk_o(brk)
  );

  // clears first, sets override
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
      nf_q   <= 1'b0;
      fe_q   <= 1'b0;
    end else begin
      if (rd_i)      full_q <= 1'b0;
      if (clr_ovr_i) ovr_q  <= 1'b0;
      if (clr_nf_i)  nf_q   <= 1'b0;
      if (clr_fe_i)  fe_q   <= 1'b0;
      if (deliver) begin
        if (!full_q) begin
          data_q <= chr;
          full_q <= 1'b1;
          nf_q   <= frm_nf;
        end else begin
          ovr_q  <= 1'b1;
        end
      end
      if (done && !stop_bit) fe_q <= 1'b1;
    end
  end

  assign data_o = data_q[7:0];
  assign bit8_o = data_q[MAX_DATA-1];
  assign full_o = full_q;
  assign ovr_o  = ovr_q;
  assign nf_o   = nf_q;
  assign fe_o   = fe_q;
endmodule

// File: rtl/uart_os_rx_chk.sv
module uart_os_rx_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic       rx_en_i,
  input logic       rd_i,
  input logic       clr_ovr_i,
  input logic       clr_nf_i,
  input logic       clr_fe_i,
  input logic [7:0] data_o,
  input logic       bit8_o,
  input logic       full_o,
  input logic       ovr_o,
  input logic       nf_o,
  input logic       fe_o
);
  AST_RD_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !tick_i |=> !full_o); // R3
  AST_CLR_FE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_fe_i && !tick_i |=> !fe_o); // R3
  AST_OVR_NEEDS_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_o) |-> $past(full_o)); // R4
  AST_DATA_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && $past(full_o) && !$past(rd_i) |-> $stable({bit8_o, data_o})); // R4
  AST_NOISE_WITH_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(nf_o) |-> $rose(full_o)); // R6
  AST_FE_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(full_o) |-> !$past(fe_o)); // R10
  AST_IDLE_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i && !rd_i && !clr_ovr_i && !clr_nf_i && !clr_fe_i
    |=> $stable({bit8_o, data_o, full_o, ovr_o, nf_o, fe_o})); // R12
endmodule

bind uart_os_rx uart_os_rx_chk u_chk (.*);

// File: tb/tb_uart_os_rx.sv
`timescale 1ns/1ps
module tb_uart_os_rx;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 1'b1, line = 1'b1, en = 1'b1, inv = 1'b0, nine = 1'b0;
  logic rd = 1'b0, clr_ovr = 1'b0, clr_nf = 1'b0, clr_fe = 1'b0;
  logic [7:0] data;
  logic bit8, full, ovr, nf, fe;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  uart_os_rx dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .rxd_i(line), .rx_en_i(en),
    .inv_i(inv), .nine_i(nine), .rd_i(rd), .clr_ovr_i(clr_ovr),
    .clr_nf_i(clr_nf), .clr_fe_i(clr_fe), .data_o(data), .bit8_o(bit8),
    .full_o(full), .ovr_o(ovr), .nf_o(nf), .fe_o(fe)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v);
    line = v ^ inv;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b1);
  endtask

  task automatic send(input logic [8:0] d, input int nb, input logic stop_v,
                      input int stop_len, input int blen, input int gbit, input int gpos);
    logic v;
    int len;
    for (int b = 0; b < nb + 2; b++) begin
      v   = (b == 0) ? 1'b0 : (b <= nb) ? d[b-1] : stop_v;
      len = (b == nb + 1) ? stop_len : blen;
      for (int k = 1; k <= len; k++) drive((b == gbit && k == gpos) ? !v : v);
    end
  endtask

  task automatic clear_all();
    rd = 1'b1; clr_ovr = 1'b1; clr_nf = 1'b1; clr_fe = 1'b1;
    @(negedge clk);
    rd = 1'b0; clr_ovr = 1'b0; clr_nf = 1'b0; clr_fe = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 full", full, 0); chk("R1 ovr", ovr, 0);
    chk("R1 nf", nf, 0);     chk("R1 fe", fe, 0);
  endtask

  task automatic t_basic();
    send(9'h0A5, 8, 1'b1, 16, 16, -1, 0);
    chk("R2 full", full, 1); chk("R2 data", data, 8'hA5);
    chk("R2 nf", nf, 0);     chk("R7 bit8 zero", bit8, 0);
    idle(4);
    rd = 1'b1; @(negedge clk); rd = 1'b0;
    chk("R3 rd clears full", full, 0);
  endtask

  task automatic t_overrun();
    send(9'h011, 8, 1'b1, 16, 16, -1, 0); idle(4);
    send(9'h022, 8, 1'b1, 16, 16, -1, 0); idle(4);
    chk("R4 ovr", ovr, 1); chk("R4 data kept", data, 8'h11);
    clr_ovr = 1'b1; @(negedge clk); clr_ovr = 1'b0;
    chk("R3 clr_ovr", ovr, 0); chk("R3 full untouched", full, 1);
    clear_all();
  endtask

  task automatic t_noise();
    send(9'h05A, 8, 1'b1, 16, 16, 3, 9); idle(4);
    chk("R6 data voted", data, 8'h5A); chk("R6 nf", nf, 1);
    clr_nf = 1'b1; @(negedge clk); clr_nf = 1'b0;
    chk("R3 clr_nf", nf, 0);
    clear_all();
  endtask

  task automatic t_false_start();
    drive(1'b0); drive(1'b0); idle(40);
    chk("R5 false start dropped", full, 0);
    send(9'h0C3, 8, 1'b1, 16, 16, 0, 5); idle(4);
    chk("R5 start 2of3 accepted", data, 8'hC3);
    chk("R6 start noise", nf, 1);
    clear_all();
  endtask

  task automatic t_nine();
    nine = 1'b1;
    send(9'h1A3, 9, 1'b1, 16, 16, -1, 0); idle(4);
    chk("R7 low bits", data, 8'hA3); chk("R7 bit8", bit8, 1);
    nine = 1'b0;
    clear_all();
  endtask

  task automatic t_invert();
    inv = 1'b1; idle(20);
    send(9'h03C, 8, 1'b1, 16, 16, -1, 0); idle(4);
    chk("R8 inverted data", data, 8'h3C); chk("R8 full", full, 1);
    inv = 1'b0; idle(20);
    clear_all();
  endtask

  task automatic t_resync();
    send(9'h055, 8, 1'b1, 15, 15, -1, 0); idle(10);
    chk("R9 data", data, 8'h55); chk("R9 nf", nf, 0);
    clear_all();
  endtask

  task automatic t_frame_err();
    send(9'h055, 8, 1'b0, 10, 16, -1, 0); idle(200);
    chk("R10 fe", fe, 1); chk("R10 data moved", data, 8'h55);
    rd = 1'b1; @(negedge clk); rd = 1'b0;
    send(9'h066, 8, 1'b1, 16, 16, -1, 0); idle(4);
    chk("R10 blocked", full, 0);
    clr_fe = 1'b1; @(negedge clk); clr_fe = 1'b0;
    chk("R3 clr_fe", fe, 0);
    send(9'h077, 8, 1'b1, 16, 16, -1, 0); idle(4);
    chk("R10 resumed", data, 8'h77);
    clear_all();
  endtask

  task automatic t_preload();
    send(9'h0F1, 8, 1'b0, 10, 16, -1, 0);
    fork
      send(9'h042, 8, 1'b1, 16, 16, -1, 0);
      begin repeat (2) @(negedge clk); clear_all(); end
    join
    idle(4);
    chk("R11 back-to-back full", full, 1);
    chk("R11 back-to-back data", data, 8'h42);
    chk("R11 fe cleared", fe, 0);
    clear_all();
    send(9'h000, 8, 1'b0, 10, 16, -1, 0);
    chk("R11 break fe", fe, 1);
    fork
      for (int i = 0; i < 40; i++) drive(1'b0);
      begin repeat (2) @(negedge clk); clear_all(); end
    join
    idle(200);
    chk("R11 break no frame", full, 0);
    chk("R11 break no fe", fe, 0);
  endtask

  task automatic t_disable();
    send(9'h0E7, 8, 1'b1, 16, 16, -1, 0); idle(4);
    en = 1'b0;
    send(9'h018, 8, 1'b1, 16, 16, -1, 0); idle(4);
    en = 1'b1; idle(20);
    chk("R12 data kept", data, 8'hE7); chk("R12 no ovr", ovr, 0);
    clear_all();
    en = 1'b0;
    send(9'h018, 8, 1'b1, 16, 16, -1, 0);
    en = 1'b1; idle(20);
    chk("R12 nothing received", full, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    idle(20);
    t_reset();
    t_basic();
    t_overrun();
    t_noise();
    t_false_start();
    t_nine();
    t_invert();
    t_resync();
    t_frame_err();
    t_preload();
    t_disable();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule